// File: doc/BRIEF.md
# Register Block Save/Restore Sequencer

This block saves a full set of eight 16-bit registers to a byte-addressed stack memory. It can also load that set back from the stack. The caller raises a one-cycle start strobe and gives the direction and the eight register values. The stack pointer is one of those eight values and sits in slot 4. The sequencer then moves one word per cycle over a simple synchronous memory port. It lowers the pointer by two bytes per word while saving and raises it by two bytes per word while restoring.

A save walks the slots in ascending order, 0 through 7. For each word the pointer is first stepped down by two, and the word is then written at the new address. The word stored for slot 4 is the pointer as it stood before the sequence began. A restore walks the slots in descending order, 7 through 0. Each word is read at the current pointer before the pointer steps up, and each word read is handed back through a register write-back port. The word read for slot 4 is dropped. The caller takes the final pointer from `sp_o` when `done_o` pulses. Neither direction touches any status flags.

Top module: `push_pop_all_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `mem_we_o`, `mem_re_o`, `reg_we_o` and `done_o` are all low.
- R2: A save (`op_pop_i`=0) makes exactly eight writes on consecutive cycles. Write k carries slot k, where slot k is `regs_i[16k+15:16k]`, at byte address S-2(k+1) modulo 2^16. S is the starting pointer from slot 4.
- R3: The word a save writes for slot 4 equals S, the pointer captured at start.
- R4: A restore (`op_pop_i`=1) makes exactly eight reads on consecutive cycles. Read k is issued at address S+2k modulo 2^16 and fetches slot 7-k.
- R5: A restore never asserts `reg_we_o` with `reg_sel_o`=4. The other seven slots are written back in the order 7,6,5,3,2,1,0.
- R6: When `done_o` is high, `sp_o` equals S-16 after a save and S+16 after a restore, both modulo 2^16.
- R7: `done_o` is high for exactly one cycle. That cycle is the ninth cycle after the clock edge that accepted the start.
- R8: A start raised while a sequence is running is ignored. The running sequence completes unchanged, and no extra memory access or done pulse follows.
- R9: `mem_we_o` and `mem_re_o` are never high together. At most one memory access happens per cycle.
- R10: Each restored word appears on `reg_wdata_o` with `reg_we_o` high one cycle after its read was issued. The memory returns read data the cycle after `mem_re_o`, with the low byte at the lower address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a sequence |
| op_pop_i | input | 1 | 0 = save all, 1 = restore all |
| regs_i | input | 128 | Eight register words, slot k at bits 16k+15:16k, slot 4 is the stack pointer |
| mem_rdata_i | input | 16 | Read word from memory, valid the cycle after a read |
| mem_addr_o | output | 16 | Byte address of the current word access |
| mem_wdata_o | output | 16 | Word to store |
| mem_we_o | output | 1 | Word write enable |
| mem_re_o | output | 1 | Word read enable |
| reg_we_o | output | 1 | Register write-back strobe during restore |
| reg_sel_o | output | 3 | Slot index being written back |
| reg_wdata_o | output | 16 | Restored register word |
| sp_o | output | 16 | Working stack pointer, final value valid with done |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A corrupted step counter or a wrong direction bit shows up on the memory port within one cycle. The address stops moving by exactly two bytes between adjacent accesses, the wrong slot's word appears on `mem_wdata_o`, or a write appears where a read belongs. A pointer register that is off shows up in the first access address and again in `sp_o` at the done pulse. The latter is nine cycles after start. A broken write-back stage shows up one cycle after the matching read, through a wrong `reg_sel_o` order or a write to slot 4. The pointer-wrap cases start the sequence near address zero and near the top of the space so that any carry mistake reaches the address port.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;
  typedef enum logic {
    OP_SAVE    = 1'b0,
    OP_RESTORE = 1'b1
  } stk_op_e;
endpackage

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
  import stk_seq_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        op_pop_i,
  output logic                        accept_o,
  output logic                        busy_o,
  output stk_op_e                     op_o,
  output logic [$clog2(NUM_REGS)-1:0] step_o,
  output logic                        done_o
);
  localparam int unsigned STEP_W = $clog2(NUM_REGS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_REGS - 1);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q;
  stk_op_e           op_q;

  // Requests arriving while busy are dropped.
  assign accept_o = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
      op_q   <= OP_SAVE;
    end else begin
      done_q <= busy_q && (step_q == LAST_STEP);
      if (accept_o) begin
        busy_q <= 1'b1;
        step_q <= '0;
        op_q   <= op_pop_i ? OP_RESTORE : OP_SAVE;
      end else if (busy_q) begin
        if (step_q == LAST_STEP) busy_q <= 1'b0;
        else                     step_q <= step_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign step_o = step_q;
  assign op_o   = op_q;
  assign done_o = done_q;
endmodule

// File: rtl/stk_slot_sel.sv
module stk_slot_sel
  import stk_seq_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          accept_i,
  input  logic [DATA_W*NUM_REGS-1:0]    regs_i,
  input  stk_op_e                       op_i,
  input  logic [$clog2(NUM_REGS)-1:0]   step_i,
  output logic [$clog2(NUM_REGS)-1:0]   slot_o,
  output logic [DATA_W-1:0]             word_o
);
  localparam int unsigned SEL_W = $clog2(NUM_REGS);
  localparam logic [SEL_W-1:0] TOP_SLOT = SEL_W'(NUM_REGS - 1);

  logic [DATA_W-1:0] snap_q [NUM_REGS];

  // Snapshot at start: the pointer slot keeps the pre-sequence pointer.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_snap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       snap_q[g] <= '0;
      else if (accept_i) snap_q[g] <= regs_i[g*DATA_W +: DATA_W];
    end
  end

  // Save ascends, restore descends.
  assign slot_o = (op_i == OP_RESTORE) ? (TOP_SLOT - step_i) : step_i;
  assign word_o = snap_q[slot_o];
endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit
  import stk_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              busy_i,
  input  stk_op_e           op_i,
  input  logic [DATA_W-1:0] sp_init_i,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] sp_o
);
  localparam logic [DATA_W-1:0] STRIDE = DATA_W'(DATA_W / 8);

  logic [DATA_W-1:0] sp_q;
  logic [DATA_W-1:0] sp_dec;
  logic [DATA_W-1:0] sp_inc;

  assign sp_dec = sp_q - STRIDE;
  assign sp_inc = sp_q + STRIDE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sp_q <= '0;
    else if (accept_i) sp_q <= sp_init_i;
    else if (busy_i)   sp_q <= (op_i == OP_RESTORE) ? sp_inc : sp_dec;
  end

  // Save: step down then store. Restore: load then step up.
  assign addr_o = (op_i == OP_RESTORE) ? sp_q : sp_dec;
  assign sp_o   = sp_q;
endmodule

// File: rtl/stk_wb_stage.sv
module stk_wb_stage #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned SP_SLOT  = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_issue_i,
  input  logic [$clog2(NUM_REGS)-1:0] slot_i,
  input  logic [DATA_W-1:0]           mem_rdata_i,
  output logic                        reg_we_o,
  output logic [$clog2(NUM_REGS)-1:0] reg_sel_o,
  output logic [DATA_W-1:0]           reg_wdata_o
);
  localparam int unsigned SEL_W = $clog2(NUM_REGS);
  localparam logic [SEL_W-1:0] PTR_SLOT = SEL_W'(SP_SLOT);

  logic             pend_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      // The saved pointer word is read but never written back.
      pend_q <= rd_issue_i && (slot_i != PTR_SLOT);
      sel_q  <= slot_i;
    end
  end

  assign reg_we_o    = pend_q;
  assign reg_sel_o   = sel_q;
  assign reg_wdata_o = mem_rdata_i;
endmodule

// File: rtl/push_pop_all_seq.sv
module push_pop_all_seq
  import stk_seq_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned SP_SLOT  = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        op_pop_i,
  input  logic [DATA_W*NUM_REGS-1:0]  regs_i,
  input  logic [DATA_W-1:0]           mem_rdata_i,
  output logic [DATA_W-1:0]           mem_addr_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  output logic                        mem_we_o,
  output logic                        mem_re_o,
  output logic                        reg_we_o,
  output logic [$clog2(NUM_REGS)-1:0] reg_sel_o,
  output logic [DATA_W-1:0]           reg_wdata_o,
  output logic [DATA_W-1:0]           sp_o,
  output logic                        done_o
);
  localparam int unsigned SEL_W = $clog2(NUM_REGS);

  logic             accept;
  logic             busy;
  stk_op_e          op;
  logic [SEL_W-1:0] step;
  logic [SEL_W-1:0] slot;

  stk_seq_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_pop_i (op_pop_i),
    .accept_o (accept),
    .busy_o   (busy),
    .op_o     (op),
    .step_o   (step),
    .done_o   (done_o)
  );

  stk_slot_sel #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .regs_i   (regs_i),
    .op_i     (op),
    .step_i   (step),
    .slot_o   (slot),
    .word_o   (mem_wdata_o)
  );

  stk_ptr_unit #(.DATA_W(DATA_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .busy_i    (busy),
    .op_i      (op),
    .sp_init_i (regs_i[SP_SLOT*DATA_W +: DATA_W]),
    .addr_o    (mem_addr_o),
    .sp_o      (sp_o)
  );

  assign mem_we_o = busy && (op == OP_SAVE);
  assign mem_re_o = busy && (op == OP_RESTORE);

  stk_wb_stage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SP_SLOT(SP_SLOT)) u_wb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_issue_i  (mem_re_o),
    .slot_i      (slot),
    .mem_rdata_i (mem_rdata_i),
    .reg_we_o    (reg_we_o),
    .reg_sel_o   (reg_sel_o),
    .reg_wdata_o (reg_wdata_o)
  );
endmodule

// File: rtl/push_pop_all_seq_chk.sv
module push_pop_all_seq_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned SP_SLOT = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              reg_we_o,
  input logic [SEL_W-1:0]  reg_sel_o,
  input logic [DATA_W-1:0] sp_o,
  input logic              done_o
);
  localparam logic [DATA_W-1:0] STRIDE = DATA_W'(DATA_W / 8);
  localparam logic [SEL_W-1:0]  PTR_SLOT = SEL_W'(SP_SLOT);

  assert_one_access_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  assert_save_stride_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - STRIDE));

  assert_restore_stride_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && $past(mem_re_o)) |-> (mem_addr_o == $past(mem_addr_o) + STRIDE));

  assert_no_ptr_wb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (reg_sel_o != PTR_SLOT));

  assert_final_ptr_save_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(mem_we_o)) |-> (sp_o == $past(mem_addr_o)));

  assert_final_ptr_restore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(mem_re_o)) |-> (sp_o == $past(mem_addr_o) + STRIDE));

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_wb_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(mem_re_o));
endmodule

bind push_pop_all_seq push_pop_all_seq_chk #(
  .DATA_W(DATA_W), .SEL_W($clog2(NUM_REGS)), .SP_SLOT(SP_SLOT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_addr_o (mem_addr_o),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .reg_we_o   (reg_we_o),
  .reg_sel_o  (reg_sel_o),
  .sp_o       (sp_o),
  .done_o     (done_o)
);

// File: tb/sim_push_pop_all_seq.sv
`timescale 1ns/1ps
module sim_push_pop_all_seq;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         op_pop_i = 1'b0;
  logic [127:0] regs_i = '0;
  logic [15:0]  mem_rdata_i = '0;
  logic [15:0]  mem_addr_o, mem_wdata_o, reg_wdata_o, sp_o;
  logic         mem_we_o, mem_re_o, reg_we_o, done_o;
  logic [2:0]   reg_sel_o;

  always #4 clk_i = ~clk_i;

  push_pop_all_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_pop_i(op_pop_i),
    .regs_i(regs_i), .mem_rdata_i(mem_rdata_i), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .reg_we_o(reg_we_o), .reg_sel_o(reg_sel_o), .reg_wdata_o(reg_wdata_o),
    .sp_o(sp_o), .done_o(done_o)
  );

  // Byte memory, little-endian word access, read data one cycle later.
  logic [7:0]  mem [0:65535];
  logic [15:0] rd_hold = '0;
  always @(negedge clk_i) begin
    if (mem_we_o) begin
      mem[mem_addr_o]         = mem_wdata_o[7:0];
      mem[mem_addr_o + 16'd1] = mem_wdata_o[15:8];
    end
    if (mem_re_o) rd_hold = {mem[mem_addr_o + 16'd1], mem[mem_addr_o]};
  end
  always @(posedge clk_i) mem_rdata_i <= rd_hold;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // Port monitor.
  logic [15:0] wr_addr [16], wr_data [16], rd_addr [16], wb_data [16];
  logic [2:0]  wb_sel [16];
  int wr_n, rd_n, wb_n, done_n, done_cyc;
  logic [15:0] sp_done;
  always @(negedge clk_i) begin
    if (mem_we_o) begin
      if (wr_n < 16) begin wr_addr[wr_n] = mem_addr_o; wr_data[wr_n] = mem_wdata_o; end
      wr_n++;
    end
    if (mem_re_o) begin
      if (rd_n < 16) rd_addr[rd_n] = mem_addr_o;
      rd_n++;
    end
    if (reg_we_o) begin
      if (wb_n < 16) begin wb_sel[wb_n] = reg_sel_o; wb_data[wb_n] = reg_wdata_o; end
      wb_n++;
    end
    if (done_o) begin done_n++; done_cyc = cyc; sp_done = sp_o; end
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] val_of(input logic [15:0] seed, input int k);
    return seed ^ (16'(k) * 16'h0101) ^ 16'h8001;
  endfunction

  function automatic logic [127:0] pack_regs(input logic [15:0] seed, input logic [15:0] sp);
    logic [127:0] r;
    for (int k = 0; k < 8; k++) r[16*k +: 16] = (k == 4) ? sp : val_of(seed, k);
    return r;
  endfunction

  int t0;
  task automatic launch(input bit pop, input logic [127:0] r);
    @(negedge clk_i);
    wr_n = 0; rd_n = 0; wb_n = 0; done_n = 0; done_cyc = -1;
    start_i = 1'b1; op_pop_i = pop; regs_i = r;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    t0 = cyc;
  endtask

  task automatic check_done(input logic [15:0] exp_sp);
    chk(done_n == 1, "R7 done count", 32'(done_n), 32'd1);
    chk(done_cyc == t0 + 8, "R7 done cycle", 32'(done_cyc - t0), 32'd8);
    chk(sp_done == exp_sp, "R6 final pointer", 32'(sp_done), 32'(exp_sp));
  endtask

  // {start pointer, seed}
  localparam logic [31:0] VEC [5] = '{
    {16'h1000, 16'h1357},
    {16'h0008, 16'hA5A0},
    {16'h0000, 16'h3C00},
    {16'hFFF4, 16'h0F0F},
    {16'h7FFE, 16'hBEEF}
  };

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: idle after reset.
    chk(!mem_we_o && !mem_re_o && !reg_we_o && !done_o, "R1 reset idle",
        {28'd0, mem_we_o, mem_re_o, reg_we_o, done_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!mem_we_o && !mem_re_o && !reg_we_o && !done_o, "R1 idle after release",
        {28'd0, mem_we_o, mem_re_o, reg_we_o, done_o}, 32'd0);

    for (int v = 0; v < 5; v++) begin
      logic [15:0] s, seed, base;
      s = VEC[v][31:16]; seed = VEC[v][15:0];
      // Save.
      launch(1'b0, pack_regs(seed, s));
      repeat (12) @(negedge clk_i);
      chk(wr_n == 8 && rd_n == 0, "R2 write count", 32'(wr_n), 32'd8);
      for (int k = 0; k < 8; k++) begin
        logic [15:0] ea, ed;
        ea = s - 16'(2 * (k + 1));
        ed = (k == 4) ? s : val_of(seed, k);
        chk(wr_addr[k] == ea, "R2 write address", 32'(wr_addr[k]), 32'(ea));
        chk(wr_data[k] == ed, (k == 4) ? "R3 pointer word" : "R2 write data",
            32'(wr_data[k]), 32'(ed));
      end
      chk(!mem_we_o && !mem_re_o && !reg_we_o, "R1 idle after save",
          {29'd0, mem_we_o, mem_re_o, reg_we_o}, 32'd0);
      check_done(s - 16'd16);
      // Restore, with junk in every slot except the pointer.
      base = s - 16'd16;
      launch(1'b1, pack_regs(~seed, base));
      repeat (12) @(negedge clk_i);
      chk(rd_n == 8 && wr_n == 0, "R4 read count", 32'(rd_n), 32'd8);
      for (int k = 0; k < 8; k++) begin
        logic [15:0] ea;
        ea = base + 16'(2 * k);
        chk(rd_addr[k] == ea, "R4 read address", 32'(rd_addr[k]), 32'(ea));
      end
      chk(wb_n == 7, "R5 writeback count", 32'(wb_n), 32'd7);
      for (int j = 0; j < 7; j++) begin
        int es;
        es = (j < 3) ? 7 - j : 6 - j;
        chk(wb_sel[j] == 3'(es), "R5 writeback order", 32'(wb_sel[j]), 32'(es));
        chk(wb_data[j] == val_of(seed, es), "R10 restored word",
            32'(wb_data[j]), 32'(val_of(seed, es)));
      end
      check_done(s);
    end

    // R8: second start during a running save is ignored.
    launch(1'b0, pack_regs(16'h2222, 16'h2000));
    repeat (3) @(negedge clk_i);
    start_i = 1'b1; op_pop_i = 1'b1; regs_i = pack_regs(16'h9999, 16'h5550);
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (12) @(negedge clk_i);
    chk(wr_n == 8, "R8 writes unchanged", 32'(wr_n), 32'd8);
    chk(rd_n == 0, "R8 no reads from ignored start", 32'(rd_n), 32'd0);
    chk(wr_data[7] == val_of(16'h2222, 7), "R8 data unchanged",
        32'(wr_data[7]), 32'(val_of(16'h2222, 7)));
    check_done(16'h1FF0);

    // R9: while a restore runs no write is raised in any step.
    launch(1'b1, pack_regs(16'h0, 16'h1FF0));
    repeat (12) @(negedge clk_i);
    chk(wr_n == 0 && rd_n == 8, "R9 single access type", 32'(wr_n), 32'd0);
    chk(wb_data[0] == val_of(16'h2222, 7), "R10 restore after ignored start",
        32'(wb_data[0]), 32'(val_of(16'h2222, 7)));

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule